// File: doc/BRIEF.md
# Programmable Multi-Sequence Event Sequencer

This block runs up to four independent state sequences over a shared pool of eight states. Every state carries an owner tag naming the sequence it belongs to, a successor for when its condition bit is true, a successor for when it is false, and two four-bit action masks: one for the true outcome and one for the false outcome. On each clock, a running sequence looks up the condition bit of its current state. It then moves to the matching successor and requests the matching actions. The requests from all sequences are ORed together and registered onto the action outputs.

The condition bits come from external combining logic, one bit per state. The action outputs drive debug consumers such as a core halt, a trace gate or a counter event. Software programs the state and sequence registers through a single write port. A sequence must be enabled and free of ownership conflicts before it runs. A synchronous restart input sends every running sequence back to its start state.

Top module: `dbg_seq_top`

## Requirements
- R1: After reset, `act_o`, `seq_active_o` and `cfg_err_o` are all zero. All state and sequence registers are zero.
- R2: One cycle after a sequence's enable bit is written to 1, the sequence is not yet running. At the following edge it becomes active at its start state, and it raises no action on that edge.
- R3: On each edge, a running sequence moves to the true successor of its current state if that state's condition bit was 1, and otherwise to the false successor.
- R4: The action mask for the evaluated outcome (true mask or false mask) appears on `act_o` in the same cycle as the state update. `act_o` returns to zero after any edge on which no evaluation requested an action.
- R5: Actions that different sequences request on the same edge are ORed bit by bit onto `act_o`.
- R6: While `restart_i` is high at an edge, every enabled, conflict-free sequence goes to its start state and no action is raised.
- R7: An enabled sequence is in conflict, and its `cfg_err_o` bit is set, in either of two cases: its start state is owned by another sequence, or a state it owns has a successor owned by another sequence. A sequence in conflict goes idle at the next edge, keeps its state output, and raises no actions. Once the conflict clears, it restarts from its start state.
- R8: A sequence whose enable bit is 0 goes idle at the next edge and raises no actions. Its `seq_state_o` field holds its last value.
- R9: Writes take effect on the next cycle. Addresses 0 to 7 select state registers with this layout: owner [1:0], true successor [4:2], false successor [7:5], true mask [11:8], false mask [15:12]. Addresses 8 to 11 select sequences 0 to 3 with this layout: enable [0], start state [3:1].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cond_i | input | 8 | Condition bit of each state |
| restart_i | input | 1 | Synchronous restart of all running sequences |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 4 | Configuration register address |
| cfg_wdata_i | input | 16 | Configuration write data |
| act_o | output | 4 | Registered action pulses |
| seq_active_o | output | 4 | Running flag for each sequence |
| seq_state_o | output | 12 | Current state of each sequence, 3 bits each, sequence 0 in the low bits |
| cfg_err_o | output | 4 | Ownership conflict flag for each sequence |

## Verification
Two sequences run side by side, and the bench sets condition bits so that both evaluate true outcomes on the same edge. The two masks then have to merge on `act_o`: masks 0010 and 0001 must give 0011, and masks 0100 and 1000 must give 1100. A second collision occurs when restart is asserted together with all-ones conditions. This checks that restart overrides both evaluations, so no action appears and both sequences land on their start states. A third case creates an ownership conflict in one sequence. On the same edge that this sequence stops, the other sequence must still advance and pulse its action.

// File: rtl/dbg_seq_pkg.sv
package dbg_seq_pkg;
    parameter int NSTATE = 8;
    parameter int NSEQ   = 4;
    parameter int NACT   = 4;

    localparam int SW = $clog2(NSTATE);
    localparam int QW = $clog2(NSEQ);
    localparam int AW = $clog2(NSTATE + NSEQ);
    localparam int DW = QW + 2 * SW + 2 * NACT;

    typedef struct packed {
        logic [NACT-1:0] act_f;
        logic [NACT-1:0] act_t;
        logic [SW-1:0]   nxt_f;
        logic [SW-1:0]   nxt_t;
        logic [QW-1:0]   owner;
    } st_cfg_t;

    typedef struct packed {
        logic [SW-1:0] start;
        logic          en;
    } sq_cfg_t;

    typedef st_cfg_t [NSTATE-1:0] st_vec_t;
    typedef sq_cfg_t [NSEQ-1:0]   sq_vec_t;
endpackage

// File: rtl/dbg_seq_cfg.sv
module dbg_seq_cfg
    import dbg_seq_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we_i,
    input  logic [AW-1:0]   addr_i,
    input  logic [DW-1:0]   wdata_i,
    output st_vec_t         st_o,
    output sq_vec_t         sq_o,
    output logic [NSEQ-1:0] err_o
);
    typedef struct packed {
        st_vec_t st;
        sq_vec_t sq;
    } regs_t;

    regs_t regs_d, regs_q;
    logic [AW-1:0] sq_idx;

    always_comb begin
        regs_d = regs_q;
        sq_idx = addr_i - AW'(NSTATE);
        if (we_i) begin
            if (int'(addr_i) < NSTATE) begin
                regs_d.st[addr_i[SW-1:0]] = wdata_i;
            end else if (int'(addr_i) < NSTATE + NSEQ) begin
                regs_d.sq[sq_idx[QW-1:0]] = wdata_i[SW:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    // ownership conflict detection per sequence
    always_comb begin
        for (int s = 0; s < NSEQ; s++) begin
            logic bad;
            bad = (regs_q.st[regs_q.sq[s].start].owner != QW'(s));
            for (int k = 0; k < NSTATE; k++) begin
                if (regs_q.st[k].owner == QW'(s)) begin
                    if (regs_q.st[regs_q.st[k].nxt_t].owner != QW'(s)) bad = 1'b1;
                    if (regs_q.st[regs_q.st[k].nxt_f].owner != QW'(s)) bad = 1'b1;
                end
            end
            err_o[s] = regs_q.sq[s].en & bad;
        end
    end

    assign st_o = regs_q.st;
    assign sq_o = regs_q.sq;

    assert_state_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && int'(addr_i) < NSTATE) |=> st_o[$past(addr_i[SW-1:0])] == $past(wdata_i));

    assert_err_needs_enable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |-> ((err_o & ~{sq_o[3].en, sq_o[2].en, sq_o[1].en, sq_o[0].en}) == '0));
endmodule

// File: rtl/dbg_seq_engine.sv
module dbg_seq_engine
    import dbg_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              err_i,
    input  logic [SW-1:0]     start_i,
    input  logic              restart_i,
    input  logic [NSTATE-1:0] cond_i,
    input  st_vec_t           st_i,
    output logic [NACT-1:0]   act_req_o,
    output logic [SW-1:0]     cur_o,
    output logic              run_o
);
    typedef struct packed {
        logic          run;
        logic [SW-1:0] cur;
    } eng_t;

    eng_t    eng_d, eng_q;
    st_cfg_t here;
    logic    hit;
    logic    go;

    always_comb begin
        eng_d     = eng_q;
        act_req_o = '0;
        here      = st_i[eng_q.cur];
        hit       = cond_i[eng_q.cur];
        go        = en_i & ~err_i;
        if (!go) begin
            eng_d.run = 1'b0;
        end else if (!eng_q.run || restart_i) begin
            eng_d.run = 1'b1;
            eng_d.cur = start_i;
        end else begin
            eng_d.cur = hit ? here.nxt_t : here.nxt_f;
            act_req_o = hit ? here.act_t : here.act_f;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) eng_q <= '0;
        else        eng_q <= eng_d;
    end

    assign cur_o = eng_q.cur;
    assign run_o = eng_q.run;

    assert_start_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(eng_q.run) |-> eng_q.cur == $past(start_i));

    assert_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_q.run && en_i && !err_i && !restart_i) |=>
        eng_q.cur == ($past(hit) ? $past(here.nxt_t) : $past(here.nxt_f)));

    assert_act_needs_run_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (act_req_o != '0) |-> eng_q.run);

    assert_restart_home_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (restart_i && en_i && !err_i) |=> eng_q.run && eng_q.cur == $past(start_i));

    assert_err_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        err_i |=> !eng_q.run);

    assert_disabled_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |-> act_req_o == '0);
endmodule

// File: rtl/dbg_seq_act.sv
module dbg_seq_act
    import dbg_seq_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NSEQ-1:0][NACT-1:0] req_i,
    output logic [NACT-1:0]           act_o
);
    logic [NACT-1:0] act_d, act_q;

    always_comb begin
        act_d = '0;
        for (int s = 0; s < NSEQ; s++) act_d = act_d | req_i[s];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) act_q <= '0;
        else        act_q <= act_d;
    end

    assign act_o = act_q;

    for (genvar g = 0; g < NSEQ; g++) begin : g_chk
        assert_merge_R5: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> (act_q & $past(req_i[g])) == $past(req_i[g]));
    end
endmodule

// File: rtl/dbg_seq_top.sv
module dbg_seq_top
    import dbg_seq_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NSTATE-1:0]  cond_i,
    input  logic               restart_i,
    input  logic               cfg_we_i,
    input  logic [AW-1:0]      cfg_addr_i,
    input  logic [DW-1:0]      cfg_wdata_i,
    output logic [NACT-1:0]    act_o,
    output logic [NSEQ-1:0]    seq_active_o,
    output logic [NSEQ*SW-1:0] seq_state_o,
    output logic [NSEQ-1:0]    cfg_err_o
);
    st_vec_t                   st_cfg;
    sq_vec_t                   sq_cfg;
    logic [NSEQ-1:0]           err;
    logic [NSEQ-1:0][NACT-1:0] req;

    dbg_seq_cfg u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (cfg_we_i),
        .addr_i  (cfg_addr_i),
        .wdata_i (cfg_wdata_i),
        .st_o    (st_cfg),
        .sq_o    (sq_cfg),
        .err_o   (err)
    );

    for (genvar s = 0; s < NSEQ; s++) begin : g_seq
        dbg_seq_engine u_eng (
            .clk       (clk),
            .rst_n     (rst_n),
            .en_i      (sq_cfg[s].en),
            .err_i     (err[s]),
            .start_i   (sq_cfg[s].start),
            .restart_i (restart_i),
            .cond_i    (cond_i),
            .st_i      (st_cfg),
            .act_req_o (req[s]),
            .cur_o     (seq_state_o[s*SW +: SW]),
            .run_o     (seq_active_o[s])
        );
    end

    dbg_seq_act u_act (
        .clk   (clk),
        .rst_n (rst_n),
        .req_i (req),
        .act_o (act_o)
    );

    assign cfg_err_o = err;

    assert_restart_silent_R6: assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |=> act_o == '0);
endmodule

// File: tb/dbg_seq_tb.sv
module dbg_seq_top_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  cond = '0;
    logic        restart = 1'b0;
    logic        we = 1'b0;
    logic [3:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [3:0]  act;
    logic [3:0]  active;
    logic [11:0] state;
    logic [3:0]  err;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    typedef struct {
        logic [3:0] act;
        logic [2:0] s0;
        logic [2:0] s1;
        logic [3:0] active;
        logic [3:0] err;
        string      tag;
    } exp_t;

    exp_t sb[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    dbg_seq_top dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .cond_i       (cond),
        .restart_i    (restart),
        .cfg_we_i     (we),
        .cfg_addr_i   (addr),
        .cfg_wdata_i  (wdata),
        .act_o        (act),
        .seq_active_o (active),
        .seq_state_o  (state),
        .cfg_err_o    (err)
    );

    function automatic void check(string tag, string what, int got, int want);
        n_chk++;
        if (got != want) begin
            n_bad++;
            $display("FAIL %s %s: got %0h expected %0h", tag, what, got, want);
        end
    endfunction

    // monitor: compares design outputs after the edge the step was applied to
    initial begin
        forever begin
            @(posedge clk);
            #1;
            while (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                check(e.tag, "act",    int'(act),         int'(e.act));
                check(e.tag, "seq0",   int'(state[2:0]),  int'(e.s0));
                check(e.tag, "seq1",   int'(state[5:3]),  int'(e.s1));
                check(e.tag, "active", int'(active),      int'(e.active));
                check(e.tag, "err",    int'(err),         int'(e.err));
            end
        end
    end

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        cond = '0; restart = 1'b0; we = 1'b1; addr = a; wdata = d;
    endtask

    task automatic step(input logic [7:0] c, input logic rs, input logic [3:0] ea,
                        input logic [2:0] e0, input logic [2:0] e1,
                        input logic [3:0] eact, input logic [3:0] eerr, input string tag);
        exp_t e;
        @(negedge clk);
        we = 1'b0; cond = c; restart = rs;
        e.act = ea; e.s0 = e0; e.s1 = e1; e.active = eact; e.err = eerr; e.tag = tag;
        sb.push_back(e);
    endtask

    function automatic logic [15:0] stw(input logic [3:0] af, input logic [3:0] at,
                                        input logic [2:0] nf, input logic [2:0] nt,
                                        input logic [1:0] own);
        return {af, at, nf, nt, own};
    endfunction

    initial begin
        #(CLK_PERIOD * 3);
        @(negedge clk);
        check("R1", "act",    int'(act),    0);
        check("R1", "active", int'(active), 0);
        check("R1", "err",    int'(err),    0);
        rst_n = 1'b1;

        // R9 layout: seq0 owns 0..2, seq1 owns 3..4
        wr(4'd0, stw(4'h0, 4'h1, 3'd0, 3'd1, 2'd0));
        wr(4'd1, stw(4'h8, 4'h2, 3'd0, 3'd2, 2'd0));
        wr(4'd2, stw(4'h0, 4'h4, 3'd2, 3'd0, 2'd0));
        wr(4'd3, stw(4'h0, 4'h1, 3'd3, 3'd4, 2'd1));
        wr(4'd4, stw(4'h4, 4'h8, 3'd4, 3'd3, 2'd1));
        wr(4'd8, 16'h0001);   // seq0 start 0, enabled
        wr(4'd9, 16'h0007);   // seq1 start 3, enabled; seq0 starts here (R2)

        step(8'h01, 0, 4'h1, 3'd1, 3'd3, 4'h3, 4'h0, "R2_R4_first");
        step(8'h0A, 0, 4'h3, 3'd2, 3'd4, 4'h3, 4'h0, "R5_merge_true");
        step(8'h00, 0, 4'h4, 3'd2, 3'd4, 4'h3, 4'h0, "R3_R4_false_path");
        step(8'h14, 0, 4'hC, 3'd0, 3'd3, 4'h3, 4'h0, "R5_merge_wrap");
        step(8'hFF, 1, 4'h0, 3'd0, 3'd3, 4'h3, 4'h0, "R6_restart");
        step(8'h00, 0, 4'h0, 3'd0, 3'd3, 4'h3, 4'h0, "R4_no_action");
        step(8'h01, 0, 4'h1, 3'd1, 3'd3, 4'h3, 4'h0, "R3_true_again");
        step(8'h00, 0, 4'h8, 3'd0, 3'd3, 4'h3, 4'h0, "R4_false_mask");

        // state 2 true successor now points into seq1: conflict for seq0
        wr(4'd2, stw(4'h0, 4'h4, 3'd2, 3'd3, 2'd0));
        step(8'hFF, 0, 4'h1, 3'd0, 3'd4, 4'h2, 4'h1, "R7_conflict_idle");
        step(8'hFF, 0, 4'h8, 3'd0, 3'd3, 4'h2, 4'h1, "R7_other_runs");
        wr(4'd2, stw(4'h0, 4'h4, 3'd2, 3'd0, 2'd0));
        step(8'h00, 0, 4'h0, 3'd0, 3'd3, 4'h3, 4'h0, "R7_resume_start");

        wr(4'd9, 16'h0006);   // seq1 disabled
        step(8'h09, 0, 4'h1, 3'd1, 3'd3, 4'h1, 4'h0, "R8_disabled_quiet");
        step(8'h02, 0, 4'h2, 3'd2, 3'd3, 4'h1, 4'h0, "R8_still_quiet");
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_chk++;
                n_bad++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule